// File: doc/BRIEF.md
# Split-Word Memory Write Port

This block gives a processor with a 16-bit write path a way to store full 32-bit words into a buffer memory. The processor selects one of four registers on each write: an address register, an upper data half, a lower data half and a command register. Writing the lower half is the trigger. If an upper half has been loaded since the last issued word, the block launches one request to the memory carrying the address, the combined word and a tag bit. It then holds that request until the memory accepts it.

When the memory accepts the request, the address register steps to the next word. A single bit in the command register arms a tag. The tag is carried by the next issued word only. While a request is outstanding, the block reports busy. During that time it drops lower-half writes, keeps upper-half writes for the following word, and holds back address writes until the pending word has gone.

Top module: `split_word_wport`

## Requirements
- R1: After reset, mem_valid_o and busy_o are 0, cur_addr_o is 0 and no tag is armed, so the first issued word carries mem_tag_o = 0.
- R2: A processor write with cpu_sel = 0 while no request is pending loads cur_addr_o from the low ADDR_W bits of cpu_wdata. The new value is visible in the next cycle.
- R3: A write with cpu_sel = 2 (lower half) that follows a write with cpu_sel = 1 (upper half) raises mem_valid_o in the next cycle. The request carries mem_addr_o = cur_addr_o and mem_data_o = {upper, lower}, with the upper half in bits 31:16.
- R4: A lower-half write with no upper-half write since reset or since the last issued word starts no request.
- R5: A raised mem_valid_o keeps mem_addr_o, mem_data_o and mem_tag_o unchanged until a clock edge with mem_ready_i high. After that edge mem_valid_o is 0.
- R6: When the memory accepts a request and no address write was held back, cur_addr_o becomes the previous value plus one, wrapping modulo 2^ADDR_W.
- R7: busy_o equals mem_valid_o. A lower-half write while busy_o is high is ignored: it starts no further request and leaves the pending data unchanged.
- R8: An address write while busy_o is high leaves cur_addr_o unchanged while the request is pending. At acceptance, cur_addr_o takes the written value in place of the increment.
- R9: A write with cpu_sel = 3 and cpu_wdata bit 0 = 1 arms the tag. The next issued word carries mem_tag_o = 1 and disarms it, so the word after carries 0. A cpu_sel = 3 write with bit 0 = 0 arms nothing.
- R10: An upper-half write while busy_o is high does not change the pending data. The next lower-half write uses it without needing another upper-half write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_we | input | 1 | Processor register write strobe |
| cpu_sel | input | 2 | Register select: 0 address, 1 upper half, 2 lower half, 3 command |
| cpu_wdata | input | HALF_W | Processor write data |
| busy_o | output | 1 | A memory request is outstanding |
| cur_addr_o | output | ADDR_W | Current word address register |
| mem_valid_o | output | 1 | Memory write request valid |
| mem_ready_i | input | 1 | Memory accepts the request at this edge |
| mem_addr_o | output | ADDR_W | Request word address |
| mem_data_o | output | 2*HALF_W | Request data word |
| mem_tag_o | output | 1 | Request tag bit |

## Verification
The bench builds the block with ADDR_W = 4 and HALF_W = 16. The narrow address lets one test reach the wrap from address 15 to 0. It also lets the bench show that a wide processor value is cut to the low address bits. The memory side can be held not-ready for several cycles. In that window the bench can make lower-half, upper-half and address writes that collide with an outstanding request. It then checks that each collision has the effect listed in the requirements.

// File: rtl/smw_pkg.sv
package smw_pkg;

    // Processor register select codes
    typedef enum logic [1:0] {
        SEL_ADDR = 2'd0,
        SEL_HI   = 2'd1,
        SEL_LO   = 2'd2,
        SEL_CMD  = 2'd3
    } smw_sel_e;

    // Bit of the command register that arms the one-shot tag
    localparam int unsigned CMD_TAG_BIT = 0;

endpackage

// File: rtl/smw_decode.sv
module smw_decode
    import smw_pkg::*;
#(
    parameter int unsigned HALF_W = 16
) (
    input  logic              we_i,
    input  logic [1:0]        sel_i,
    input  logic [HALF_W-1:0] wdata_i,
    output logic              wr_addr_o,
    output logic              wr_hi_o,
    output logic              wr_lo_o,
    output logic              set_tag_o
);

    smw_sel_e sel;

    always_comb begin
        sel       = smw_sel_e'(sel_i);
        wr_addr_o = we_i && (sel == SEL_ADDR);
        wr_hi_o   = we_i && (sel == SEL_HI);
        wr_lo_o   = we_i && (sel == SEL_LO);
        set_tag_o = we_i && (sel == SEL_CMD) && wdata_i[CMD_TAG_BIT];
    end

endmodule

// File: rtl/smw_stage.sv
module smw_stage #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_addr_i,
    input  logic              wr_hi_i,
    input  logic              wr_lo_i,
    input  logic              set_tag_i,
    input  logic [HALF_W-1:0] wdata_i,
    input  logic              busy_i,
    input  logic              ack_i,
    output logic              issue_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [HALF_W-1:0] hi_o,
    output logic              tag_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] park;
        logic              park_vld;
        logic [HALF_W-1:0] hi;
        logic              hi_ok;
        logic              tag_arm;
    } stage_t;

    stage_t            s_d, s_q;
    logic [ADDR_W-1:0] wr_val;
    logic              issue;

    // Fit processor data to the address width
    generate
        if (ADDR_W <= HALF_W) begin : g_trunc
            assign wr_val = wdata_i[ADDR_W-1:0];
        end else begin : g_extend
            assign wr_val = {{(ADDR_W-HALF_W){1'b0}}, wdata_i};
        end
    endgenerate

    always_comb begin
        issue = wr_lo_i && s_q.hi_ok && !busy_i;
        s_d   = s_q;

        if (wr_hi_i) begin
            s_d.hi    = wdata_i;
            s_d.hi_ok = 1'b1;
        end
        if (issue) begin
            s_d.hi_ok   = 1'b0;
            s_d.tag_arm = 1'b0;
        end
        if (set_tag_i) begin
            s_d.tag_arm = 1'b1;
        end

        if (!busy_i) begin
            if (wr_addr_i) begin
                s_d.addr = wr_val;
            end
        end else if (ack_i) begin
            if (wr_addr_i) begin
                s_d.addr = wr_val;
            end else if (s_q.park_vld) begin
                s_d.addr = s_q.park;
            end else begin
                s_d.addr = s_q.addr + ADDR_W'(1);
            end
            s_d.park_vld = 1'b0;
        end else if (wr_addr_i) begin
            s_d.park     = wr_val;
            s_d.park_vld = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign issue_o = issue;
    assign addr_o  = s_q.addr;
    assign hi_o    = s_q.hi;
    assign tag_o   = s_q.tag_arm;

    AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i && !ack_i |=> $stable(s_q.addr)); // R8

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i && !wr_addr_i && !s_q.park_vld |=> s_q.addr == ADDR_W'($past(s_q.addr) + 1'b1)); // R6

    AST_TAG_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> !s_q.tag_arm); // R9

endmodule

// File: rtl/smw_req.sv
module smw_req #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              tag_i,
    input  logic              ready_i,
    output logic              valid_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o,
    output logic              tag_o,
    output logic              ack_o
);

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              tag;
    } req_t;

    req_t r_d, r_q;
    logic ack;

    always_comb begin
        ack = r_q.vld && ready_i;
        r_d = r_q;
        if (ack) begin
            r_d.vld = 1'b0;
        end
        if (issue_i && !r_q.vld) begin
            r_d.vld  = 1'b1;
            r_d.addr = addr_i;
            r_d.data = data_i;
            r_d.tag  = tag_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign valid_o = r_q.vld;
    assign addr_o  = r_q.addr;
    assign data_o  = r_q.data;
    assign tag_o   = r_q.tag;
    assign ack_o   = ack;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.vld && !ready_i |=> r_q.vld && $stable(r_q.addr) && $stable(r_q.data) && $stable(r_q.tag)); // R5

    AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.vld && ready_i |=> !r_q.vld); // R5

endmodule

// File: rtl/split_word_wport.sv
module split_word_wport #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned HALF_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cpu_we,
    input  logic [1:0]            cpu_sel,
    input  logic [HALF_W-1:0]     cpu_wdata,
    output logic                  busy_o,
    output logic [ADDR_W-1:0]     cur_addr_o,
    output logic                  mem_valid_o,
    input  logic                  mem_ready_i,
    output logic [ADDR_W-1:0]     mem_addr_o,
    output logic [2*HALF_W-1:0]   mem_data_o,
    output logic                  mem_tag_o
);

    localparam int unsigned DATA_W = 2 * HALF_W;

    logic              wr_addr, wr_hi, wr_lo, set_tag;
    logic              issue, ack, pend;
    logic [ADDR_W-1:0] addr_q;
    logic [HALF_W-1:0] hi_q;
    logic              tag_q;

    smw_decode #(.HALF_W(HALF_W)) u_decode (
        .we_i      (cpu_we),
        .sel_i     (cpu_sel),
        .wdata_i   (cpu_wdata),
        .wr_addr_o (wr_addr),
        .wr_hi_o   (wr_hi),
        .wr_lo_o   (wr_lo),
        .set_tag_o (set_tag)
    );

    smw_stage #(.ADDR_W(ADDR_W), .HALF_W(HALF_W)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_addr_i (wr_addr),
        .wr_hi_i   (wr_hi),
        .wr_lo_i   (wr_lo),
        .set_tag_i (set_tag),
        .wdata_i   (cpu_wdata),
        .busy_i    (pend),
        .ack_i     (ack),
        .issue_o   (issue),
        .addr_o    (addr_q),
        .hi_o      (hi_q),
        .tag_o     (tag_q)
    );

    smw_req #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .issue_i (issue),
        .addr_i  (addr_q),
        .data_i  ({hi_q, cpu_wdata}),
        .tag_i   (tag_q),
        .ready_i (mem_ready_i),
        .valid_o (pend),
        .addr_o  (mem_addr_o),
        .data_o  (mem_data_o),
        .tag_o   (mem_tag_o),
        .ack_o   (ack)
    );

    assign busy_o      = pend;
    assign mem_valid_o = pend;
    assign cur_addr_o  = addr_q;

    AST_RISE_FROM_LO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_valid_o) |-> $past(cpu_we && cpu_sel == 2'd2)); // R3

    AST_BUSY_LO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_data_o)); // R7

endmodule

// File: tb/split_word_wport_bench.sv
module split_word_wport_bench;

    localparam int unsigned PERIOD = 10;
    localparam int unsigned ADDR_W = 4;
    localparam int unsigned HALF_W = 16;
    localparam int unsigned ITEM_W = ADDR_W + 2*HALF_W + 1;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                cpu_we = 1'b0;
    logic [1:0]          cpu_sel = '0;
    logic [HALF_W-1:0]   cpu_wdata = '0;
    logic                busy, mem_valid, mem_tag;
    logic                mem_ready = 1'b1;
    logic [ADDR_W-1:0]   cur_addr, mem_addr;
    logic [2*HALF_W-1:0] mem_data;

    int unsigned nchk = 0;
    int unsigned nfail = 0;
    bit          done = 1'b0;
    logic [ITEM_W-1:0] sb_q[$];

    always #(PERIOD/2) clk = ~clk;

    split_word_wport #(.ADDR_W(ADDR_W), .HALF_W(HALF_W)) u_split_word_wport (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_we      (cpu_we),
        .cpu_sel     (cpu_sel),
        .cpu_wdata   (cpu_wdata),
        .busy_o      (busy),
        .cur_addr_o  (cur_addr),
        .mem_valid_o (mem_valid),
        .mem_ready_i (mem_ready),
        .mem_addr_o  (mem_addr),
        .mem_data_o  (mem_data),
        .mem_tag_o   (mem_tag)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [HALF_W-1:0] d);
        @(negedge clk);
        cpu_we = 1'b1; cpu_sel = sel; cpu_wdata = d;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic set_ready(input logic v);
        @(negedge clk);
        mem_ready = v;
    endtask

    task automatic expect_word(input logic [ADDR_W-1:0] a, input logic [2*HALF_W-1:0] d, input logic t);
        sb_q.push_back({a, d, t});
    endtask

    // Monitor: compares each accepted request against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (rst_n && mem_valid && mem_ready) begin
                if (sb_q.size() == 0) begin
                    check("R4 R7 unexpected request", 1, 0);
                end else begin
                    check("R3 R9 request content", {mem_addr, mem_data, mem_tag}, sb_q.pop_front());
                end
            end
        end
    end

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", mem_valid, 0);
        check("R1 busy after reset", busy, 0);
        check("R1 addr after reset", cur_addr, 0);

        // R2 address load
        wr(2'd0, 16'd5);
        check("R2 address load", cur_addr, 5);

        // R3 basic word, ready high
        expect_word(4'd5, 32'hA1A2_B1B2, 1'b0);
        wr(2'd1, 16'hA1A2);
        wr(2'd2, 16'hB1B2);
        check("R3 valid raised", mem_valid, 1);
        check("R7 busy follows valid", busy, 1);
        @(negedge clk);
        check("R5 valid dropped after accept", mem_valid, 0);
        check("R6 address step", cur_addr, 6);

        // R4 lower without upper
        wr(2'd2, 16'hC0C0);
        check("R4 no request", mem_valid, 0);
        @(negedge clk);
        check("R4 address unchanged", cur_addr, 6);

        // R5 stall with collisions
        set_ready(1'b0);
        expect_word(4'd6, 32'h1111_2222, 1'b0);
        wr(2'd1, 16'h1111);
        wr(2'd2, 16'h2222);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R5 held valid", mem_valid, 1);
            check("R5 held data", mem_data, 32'h1111_2222);
            check("R5 held addr", mem_addr, 6);
        end
        wr(2'd2, 16'hDDDD);
        check("R7 lower ignored while busy", mem_data, 32'h1111_2222);
        wr(2'd1, 16'hEEEE);
        check("R10 pending data unchanged", mem_data, 32'h1111_2222);
        wr(2'd0, 16'd9);
        check("R8 address frozen while pending", cur_addr, 6);
        check("R7 still busy", busy, 1);
        set_ready(1'b1);
        @(negedge clk);
        check("R8 held address applied", cur_addr, 9);
        check("R7 busy cleared", busy, 0);
        expect_word(4'd9, 32'hEEEE_FFFF, 1'b0);
        wr(2'd2, 16'hFFFF);
        check("R10 kept upper reused", mem_valid, 1);
        @(negedge clk);
        check("R6 address step after held", cur_addr, 10);

        // R9 tag one-shot
        wr(2'd3, 16'h0001);
        expect_word(4'd10, 32'h3333_4444, 1'b1);
        wr(2'd1, 16'h3333);
        wr(2'd2, 16'h4444);
        check("R9 tag on armed word", mem_tag, 1);
        @(negedge clk);
        expect_word(4'd11, 32'h5555_6666, 1'b0);
        wr(2'd1, 16'h5555);
        wr(2'd2, 16'h6666);
        check("R9 tag cleared", mem_tag, 0);
        @(negedge clk);
        wr(2'd3, 16'h0002);
        expect_word(4'd12, 32'h7777_8888, 1'b0);
        wr(2'd1, 16'h7777);
        wr(2'd2, 16'h8888);
        check("R9 bit0 clear arms nothing", mem_tag, 0);
        @(negedge clk);

        // R2 truncation, R6 wrap
        wr(2'd0, 16'h1234);
        check("R2 truncated address", cur_addr, 4);
        wr(2'd0, 16'd15);
        expect_word(4'd15, 32'h9999_AAAA, 1'b0);
        wr(2'd1, 16'h9999);
        wr(2'd2, 16'hAAAA);
        @(negedge clk);
        check("R6 address wrap", cur_addr, 0);

        repeat (4) @(negedge clk);
        check("R5 all requests delivered", sb_q.size(), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule